// File: doc/BRIEF.md
# Transmit Interrupt Status and Masking Unit

This block sits beside the transmit FIFO of an audio codec interface. It turns the FIFO's status into a small vector of raw interrupt causes and a single interrupt request line. The FIFO supplies three status levels: half-empty, empty and transmitter busy. It also supplies a one-cycle pulse when it drains to empty. The bus decoder supplies an interrupt-enable vector and a write strobe with data for the write-one-to-clear command.

The status levels are captured in registers. The raw causes are formed from those registered levels. There are three causes:
- The underrun cause is sticky. It is set by the drain pulse and held until software clears it.
- The transmit-request cause follows half-empty live.
- The transmit-complete cause follows "not busy and empty" live.

The interrupt line is the registered OR of the raw causes gated by their enables, so it cannot glitch. A combined readback returns the raw vector zero-extended to the bus width.

Top module: `tx_irq_status`

## Requirements
- R1: While reset is held (rstN low), rawStatus, allInts and irqOut are all zero.
- R2: A one-cycle underrunPulse sets rawStatus bit 0 (underrun) on the next clock edge, and the bit stays set across any number of later cycles until a clear.
- R3: A clear write (clrWe high with clrData bit CLR_UNDR_BIT, default bit 0, set) drops rawStatus bit 0 on the next edge. A clear write without that bit has no effect on bit 0.
- R4: When a clear write and underrunPulse arrive in the same cycle, the clear wins and rawStatus bit 0 is low after the edge.
- R5: rawStatus bit 1 (transmit request) equals the halfEmpty input sampled at the previous clock edge, in both directions.
- R6: rawStatus bit 2 (transmit complete) equals (not txBusy) and fifoEmpty sampled at the previous clock edge.
- R7: irqOut is the OR, taken over all bits, of rawStatus AND intEnable, as it was in the cycle before the edge. A cause with its enable bit low does not raise irqOut.
- R8: allInts carries rawStatus in bits 6:0 and zero in every bit above.
- R9: rawStatus bits 6:3 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| underrunPulse | input | 1 | One-cycle pulse from the FIFO when it drains to empty |
| halfEmpty | input | 1 | FIFO half-empty status level |
| fifoEmpty | input | 1 | FIFO empty status level |
| txBusy | input | 1 | Transmitter busy status level |
| intEnable | input | 7 | Per-cause interrupt enable |
| clrWe | input | 1 | Write strobe for the clear command |
| clrData | input | DATA_W | Clear command data, write-one-to-clear |
| rawStatus | output | 7 | Raw interrupt causes |
| allInts | output | DATA_W | Combined readback, raw causes zero-extended |
| irqOut | output | 1 | Registered masked interrupt request |

## Verification
The underrun flag is the only state that lives longer than one cycle. If it is lost, it shows at rawStatus bit 0 on the cycle after the pulse. If it is left over when it should not be, it shows as soon as a clear or a same-cycle clear and set has taken effect. A stale or mis-registered status level shows at rawStatus one edge after the input changes. A wrong mask or a missing output register shows on irqOut one edge after that. Each scenario therefore samples rawStatus one cycle after the stimulus and irqOut one cycle later.

// File: rtl/tx_irq_pkg.sv
package tx_irq_pkg;
  // Width of the raw cause vector and the position of each cause in it.
  localparam int RAW_W     = 7;
  localparam int UNDR_IDX  = 0;
  localparam int TXREQ_IDX = 1;
  localparam int DONE_IDX  = 2;
  localparam int USED_W    = 3;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic setUndr;
    logic clrUndr;
  } undrCmd_t;
endpackage

// File: rtl/tx_irq_ctrl.sv
module tx_irq_ctrl
  import tx_irq_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int CLR_UNDR_BIT = 0
) (
  input  logic              underrunPulse,
  input  logic              clrWe,
  input  logic [DATA_W-1:0] clrData,
  output undrCmd_t          cmd
);
  // Decode the write-one-to-clear command. The clear is given priority
  // here, so the datapath never sees both strobes together.
  logic clrHit;

  always_comb begin
    clrHit      = clrWe && clrData[CLR_UNDR_BIT];
    cmd.clrUndr = clrHit;
    cmd.setUndr = underrunPulse && !clrHit;
  end
endmodule

// File: rtl/tx_irq_datapath.sv
module tx_irq_datapath
  import tx_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  undrCmd_t          cmd,
  input  logic              halfEmpty,
  input  logic              fifoEmpty,
  input  logic              txBusy,
  input  logic [RAW_W-1:0]  intEnable,
  output logic [RAW_W-1:0]  rawStatus,
  output logic [DATA_W-1:0] allInts,
  output logic              irqOut
);
  localparam int PAD_W = DATA_W - RAW_W;

  logic stHalf, stEmpty, stBusy, undrQ, irqQ;
  logic [RAW_W-1:0] rawVec;

  // Registered copies of the FIFO status levels.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stHalf  <= 1'b0;
      stEmpty <= 1'b0;
      stBusy  <= 1'b0;
    end else begin
      stHalf  <= halfEmpty;
      stEmpty <= fifoEmpty;
      stBusy  <= txBusy;
    end
  end

  // Sticky underrun flag. The control half never raises both strobes
  // together, so the order of these branches is only a fallback.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      undrQ <= 1'b0;
    end else if (cmd.clrUndr) begin
      undrQ <= 1'b0;
    end else if (cmd.setUndr) begin
      undrQ <= 1'b1;
    end
  end

  // Raw causes. Bits above the used ones are tied low.
  always_comb begin
    rawVec            = '0;
    rawVec[UNDR_IDX]  = undrQ;
    rawVec[TXREQ_IDX] = stHalf;
    rawVec[DONE_IDX]  = stEmpty && !stBusy;
  end

  genvar gi;
  generate
    for (gi = 0; gi < RAW_W; gi++) begin : g_raw
      if (gi < USED_W) begin : g_used
        assign rawStatus[gi] = rawVec[gi];
      end else begin : g_rsvd
        assign rawStatus[gi] = 1'b0;
      end
    end
  endgenerate

  // Registered masked request, so the line carries no glitches.
  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |(rawStatus & intEnable);
  end

  assign irqOut  = irqQ;
  assign allInts = {{PAD_W{1'b0}}, rawStatus};
endmodule

// File: rtl/tx_irq_status.sv
module tx_irq_status
  import tx_irq_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int CLR_UNDR_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              underrunPulse,
  input  logic              halfEmpty,
  input  logic              fifoEmpty,
  input  logic              txBusy,
  input  logic [6:0]        intEnable,
  input  logic              clrWe,
  input  logic [DATA_W-1:0] clrData,
  output logic [6:0]        rawStatus,
  output logic [DATA_W-1:0] allInts,
  output logic              irqOut
);
  undrCmd_t cmd;

  tx_irq_ctrl #(.DATA_W(DATA_W), .CLR_UNDR_BIT(CLR_UNDR_BIT)) ctrl_i (
    .underrunPulse(underrunPulse),
    .clrWe        (clrWe),
    .clrData      (clrData),
    .cmd          (cmd)
  );

  tx_irq_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .halfEmpty(halfEmpty),
    .fifoEmpty(fifoEmpty),
    .txBusy   (txBusy),
    .intEnable(intEnable),
    .rawStatus(rawStatus),
    .allInts  (allInts),
    .irqOut   (irqOut)
  );
endmodule

// File: rtl/tx_irq_chk.sv
module tx_irq_chk #(
  parameter int DATA_W       = 32,
  parameter int CLR_UNDR_BIT = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              underrunPulse,
  input logic              halfEmpty,
  input logic              fifoEmpty,
  input logic              txBusy,
  input logic [6:0]        intEnable,
  input logic              clrWe,
  input logic [DATA_W-1:0] clrData,
  input logic [6:0]        rawStatus,
  input logic [DATA_W-1:0] allInts,
  input logic              irqOut
);
  // Armed one cycle after reset is released, so $past never reaches back
  // into reset.
  logic armed;
  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  logic clrHit;
  assign clrHit = clrWe && clrData[CLR_UNDR_BIT];

  // R2
  undr_set_chk: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (underrunPulse && !clrHit) |=> rawStatus[0]);
  // R2
  undr_hold_chk: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (rawStatus[0] && !clrHit) |=> rawStatus[0]);
  // R3
  undr_clr_chk: assert property (@(posedge clk) disable iff (!rstN || !armed)
    clrHit |=> !rawStatus[0]);
  // R4
  undr_prio_chk: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (clrHit && underrunPulse) |=> !rawStatus[0]);
  // R5
  txreq_follow_chk: assert property (@(posedge clk) disable iff (!rstN || !armed)
    rawStatus[1] == $past(halfEmpty));
  // R6
  done_follow_chk: assert property (@(posedge clk) disable iff (!rstN || !armed)
    rawStatus[2] == $past(fifoEmpty && !txBusy));
  // R7
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rstN || !armed)
    irqOut == $past(|(rawStatus & intEnable)));
  // R8
  readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    allInts == {{(DATA_W-7){1'b0}}, rawStatus});
  // R9
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rawStatus[6:3] == 4'b0000);
endmodule

bind tx_irq_status tx_irq_chk #(.DATA_W(DATA_W), .CLR_UNDR_BIT(CLR_UNDR_BIT)) chk_i (
  .clk(clk), .rstN(rstN), .underrunPulse(underrunPulse), .halfEmpty(halfEmpty),
  .fifoEmpty(fifoEmpty), .txBusy(txBusy), .intEnable(intEnable), .clrWe(clrWe),
  .clrData(clrData), .rawStatus(rawStatus), .allInts(allInts), .irqOut(irqOut)
);

// File: tb/tx_irq_status_tb.sv
module tx_irq_status_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic underrunPulse = 1'b0, halfEmpty = 1'b0, fifoEmpty = 1'b0, txBusy = 1'b0;
  logic [6:0] intEnable = '0;
  logic clrWe = 1'b0;
  logic [DATA_W-1:0] clrData = '0;
  logic [6:0] rawStatus;
  logic [DATA_W-1:0] allInts;
  logic irqOut;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_irq_status #(.DATA_W(DATA_W), .CLR_UNDR_BIT(0)) dut_i (
    .clk(clk), .rstN(rstN), .underrunPulse(underrunPulse), .halfEmpty(halfEmpty),
    .fifoEmpty(fifoEmpty), .txBusy(txBusy), .intEnable(intEnable), .clrWe(clrWe),
    .clrData(clrData), .rawStatus(rawStatus), .allInts(allInts), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic checkReadback(input string req);
    check(req, allInts, {{(DATA_W-7){1'b0}}, rawStatus});
    check(req, {28'd0, rawStatus[6:3]}, '0);
  endtask

  task automatic testReset();
    tick(); tick();
    check("R1 raw", {25'd0, rawStatus}, '0);
    check("R1 all", allInts, '0);
    check("R1 irq", {31'd0, irqOut}, '0);
    rstN = 1'b1;
    tick();
  endtask

  task automatic testUnderrunSticky();
    underrunPulse = 1'b1; tick();
    underrunPulse = 1'b0;
    check("R2 set", {31'd0, rawStatus[0]}, 1);
    for (int i = 0; i < 5; i++) tick();
    check("R2 held", {31'd0, rawStatus[0]}, 1);
    checkReadback("R8 underrun");
  endtask

  task automatic testClear();
    clrWe = 1'b1; clrData = 32'hFFFF_FFFE; tick();
    clrWe = 1'b0; clrData = '0; tick();
    check("R3 wrong bit no effect", {31'd0, rawStatus[0]}, 1);
    clrWe = 1'b1; clrData = 32'h0000_0001; tick();
    clrWe = 1'b0; clrData = '0;
    check("R3 cleared", {31'd0, rawStatus[0]}, 0);
    tick();
    check("R3 stays clear", {31'd0, rawStatus[0]}, 0);
  endtask

  task automatic testPriority();
    underrunPulse = 1'b1; clrWe = 1'b1; clrData = 32'h1; tick();
    underrunPulse = 1'b0; clrWe = 1'b0; clrData = '0;
    check("R4 clear wins", {31'd0, rawStatus[0]}, 0);
    underrunPulse = 1'b1; tick();
    underrunPulse = 1'b0;
    clrWe = 1'b1; clrData = 32'h1; underrunPulse = 1'b1; tick();
    clrWe = 1'b0; clrData = '0; underrunPulse = 1'b0;
    check("R4 clear wins while set", {31'd0, rawStatus[0]}, 0);
  endtask

  task automatic testHalfEmpty();
    halfEmpty = 1'b1; tick();
    check("R5 rise", {31'd0, rawStatus[1]}, 1);
    halfEmpty = 1'b0; tick();
    check("R5 fall", {31'd0, rawStatus[1]}, 0);
  endtask

  task automatic testComplete();
    for (int p = 0; p < 4; p++) begin
      fifoEmpty = p[0]; txBusy = p[1]; tick();
      check("R6 complete", {31'd0, rawStatus[2]}, {31'd0, (p[0] && !p[1])});
      checkReadback("R9 reserved");
    end
    fifoEmpty = 1'b0; txBusy = 1'b0; tick();
  endtask

  task automatic testIrqMask();
    // Raise transmit request with its enable off: no interrupt.
    intEnable = 7'b000_0101; halfEmpty = 1'b1; tick(); tick();
    check("R7 masked", {31'd0, irqOut}, 0);
    intEnable = 7'b000_0010; tick();
    check("R7 enabled", {31'd0, irqOut}, 1);
    halfEmpty = 1'b0; tick();
    check("R7 still high one cycle", {31'd0, irqOut}, 1);
    tick();
    check("R7 drops", {31'd0, irqOut}, 0);
    intEnable = 7'b000_0001; underrunPulse = 1'b1; tick();
    underrunPulse = 1'b0; tick();
    check("R7 underrun irq", {31'd0, irqOut}, 1);
    intEnable = '0; tick();
    check("R7 all masked", {31'd0, irqOut}, 0);
    clrWe = 1'b1; clrData = 32'h1; tick();
    clrWe = 1'b0; clrData = '0; tick();
  endtask

  initial begin
    testReset();
    testUnderrunSticky();
    testClear();
    testPriority();
    testHalfEmpty();
    testComplete();
    testIrqMask();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule